// File: doc/BRIEF.md
# Timed Asynchronous SRAM Controller

This block sits between a simple clocked host port and a 32K x 8 asynchronous static RAM. The host raises a one-cycle request with a read/write flag, an address and write data. The controller plays out the memory pin sequence for that access and answers with a one-cycle done pulse. A read also returns the byte it captured. Only one access is in flight at a time. New requests are taken only while the controller is idle, and a request that arrives while an access is under way is dropped.

Every phase length is a whole number of clock cycles. Each one is derived when the block elaborates from a nanosecond limit and the clock-period parameter: the limit is divided by the period, rounded up, and held to at least one cycle. The phases cover the write-enable low width, data valid before write enable rises, write-enable high recovery between pulses, read access from both address and output enable, and the delay before the controller drives data after the memory has been told to release the bus. Writes are always timed by write enable. Chip select and the address are already steady before write enable falls.

Top module: `sram_timed_ctrl`

## Requirements
- R1: While reset is held, chip enable is low, chip select, write enable and output enable are high (inactive), the data driver is off and done is low. From the first cycle after reset, and whenever no access is running, chip enable is high and chip select is high (deselected).
- R2: A read (host_wr = 0) holds chip select and output enable low, with write enable and chip enable high and the requested address on the pins. Done follows and returns the byte the memory presented.
- R3: Read data is captured only after the address and output enable have been active for max(ceil(25/P), ceil(9/P)) cycles, where P is the clock period in ns. With P = 10 this is 3 cycles, and done comes 4 cycles after the accepting edge.
- R4: A write (host_wr = 1) drops write enable for exactly max(ceil(20/P), ceil(15/P)) cycles (2 at P = 10). Write enable is only ever low while chip select is low, chip enable is high and output enable is high.
- R5: During a write the data driver is on before write enable falls. Address and write data stay unchanged while write enable is low, and the memory stores the requested byte at the requested address.
- R6: Between two write pulses, write enable stays high for at least ceil(5/P) cycles, with a minimum of 1.
- R7: The data driver is never on while output enable is low. After output enable rises, the driver stays off for at least ceil(10/P) cycles.
- R8: Each access yields exactly one done pulse one cycle wide. A write raises done 1 + pulse + recovery cycles after the accepting edge (4 at P = 10).
- R9: A request raised while an access is running is ignored. It produces no extra done and no write pulse, and memory is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Access request, sampled only when idle |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address of the access |
| host_wdata | input | DATA_W | Byte to write |
| host_rdata | output | DATA_W | Byte captured by the last read |
| host_done | output | 1 | One-cycle completion pulse |
| mem_ce | output | 1 | Memory chip enable, active high |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_oe | output | 1 | Enable of the controller's data driver |
| mem_dq_in | input | DATA_W | Data returned by the memory |

## Verification
The assertions assume the host raises a request only when the previous access has ended. They also assume the memory inputs are meaningful only while output enable is low. The window counters start each reset with write enable already high. The stimulus issues the next access only after it sees done, or holds a request across a busy period on purpose to show that it is dropped. The memory model returns a poison byte until address and output enable have been steady for the full access count, so the returned data exposes a capture that comes too early.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_RECOVER
    } sramc_state_e;

    // Round a nanosecond limit up to whole clock cycles, never below one.
    function automatic int ns_to_cyc(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sramc_phase_tmr.sv
// Down counter that times one phase: loaded with length-1 on phase entry,
// flags the final cycle of the phase.
module sramc_phase_tmr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last = (cnt_q == '0);

endmodule

// File: rtl/sramc_turn_guard.sv
// Counts cycles since output enable was last active and tells the sequencer
// whether the data driver may be on in the next cycle.
module sramc_turn_guard #(
    parameter int TURN_CYC = 1,
    parameter int W        = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic ok_next
);
    localparam logic [W-1:0] TURN_V = W'(TURN_CYC);

    logic [W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (!oe_n) begin
            gap_d = '0;
        end else if (gap_q < TURN_V) begin
            gap_d = gap_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= TURN_V;
        end else begin
            gap_q <= gap_d;
        end
    end

    // After the coming edge the gap will be gap_q + 1 (if oe stays high).
    assign ok_next = oe_n && ((int'(gap_q) + 1) >= TURN_CYC);

endmodule

// File: rtl/sramc_seq.sv
// Access sequencer: owns every memory pin register and the host handshake.
module sramc_seq
    import sramc_pkg::*;
#(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int TMR_W     = 2,
    parameter int RD_CYC    = 3,
    parameter int PULSE_CYC = 2,
    parameter int REC_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              tmr_last,
    input  logic              turn_ok_next,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic [DATA_W-1:0] rdata,
    output logic              done,
    output logic              ce,
    output logic              cs_n,
    output logic              we_n,
    output logic              oe_n,
    output logic              drv,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata
);
    localparam logic [TMR_W-1:0] RD_LD    = TMR_W'(RD_CYC - 1);
    localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] REC_LD   = TMR_W'(REC_CYC - 1);

    typedef struct packed {
        sramc_state_e      st;
        logic              ce;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (s_q.st)
            ST_IDLE: begin
                s_d.ce   = 1'b1;
                s_d.cs_n = 1'b1;
                s_d.we_n = 1'b1;
                s_d.oe_n = 1'b1;
                s_d.drv  = 1'b0;
                if (host_req) begin
                    s_d.addr  = host_addr;
                    s_d.wdata = host_wdata;
                    s_d.cs_n  = 1'b0;
                    if (host_wr) begin
                        s_d.st  = ST_WR_SETUP;
                        s_d.drv = turn_ok_next;
                    end else begin
                        s_d.st   = ST_RD_ACCESS;
                        s_d.oe_n = 1'b0;
                        tmr_load = 1'b1;
                        tmr_val  = RD_LD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (tmr_last) begin
                    s_d.rdata = mem_rdata;
                    s_d.oe_n  = 1'b1;
                    s_d.cs_n  = 1'b1;
                    s_d.st    = ST_RD_DONE;
                end
            end
            ST_RD_DONE: begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end
            ST_WR_SETUP: begin
                if (s_q.drv) begin
                    s_d.we_n = 1'b0;
                    s_d.st   = ST_WR_PULSE;
                    tmr_load = 1'b1;
                    tmr_val  = PULSE_LD;
                end else begin
                    s_d.drv = turn_ok_next;
                end
            end
            ST_WR_PULSE: begin
                if (tmr_last) begin
                    s_d.we_n = 1'b1;
                    s_d.cs_n = 1'b1;
                    s_d.st   = ST_WR_RECOVER;
                    tmr_load = 1'b1;
                    tmr_val  = REC_LD;
                end
            end
            ST_WR_RECOVER: begin
                if (tmr_last) begin
                    s_d.drv  = 1'b0;
                    s_d.done = 1'b1;
                    s_d.st   = ST_IDLE;
                end
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st    <= ST_IDLE;
            s_q.ce    <= 1'b0;
            s_q.cs_n  <= 1'b1;
            s_q.we_n  <= 1'b1;
            s_q.oe_n  <= 1'b1;
            s_q.drv   <= 1'b0;
            s_q.addr  <= '0;
            s_q.wdata <= '0;
            s_q.rdata <= '0;
            s_q.done  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rdata = s_q.rdata;
    assign done  = s_q.done;
    assign ce    = s_q.ce;
    assign cs_n  = s_q.cs_n;
    assign we_n  = s_q.we_n;
    assign oe_n  = s_q.oe_n;
    assign drv   = s_q.drv;
    assign addr  = s_q.addr;
    assign wdata = s_q.wdata;

endmodule

// File: rtl/sram_timed_ctrl.sv
module sram_timed_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W          = 15,
    parameter int DATA_W          = 8,
    parameter int CLK_PERIOD_NS   = 10,
    parameter int T_WE_PULSE_NS   = 20,
    parameter int T_DATA_SETUP_NS = 15,
    parameter int T_WE_RECOV_NS   = 5,
    parameter int T_ADDR_ACC_NS   = 25,
    parameter int T_OE_ACC_NS     = 9,
    parameter int T_BUS_OFF_NS    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_done,
    output logic              mem_ce,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int PULSE_CYC = max_of(ns_to_cyc(T_WE_PULSE_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_DATA_SETUP_NS, CLK_PERIOD_NS));
    localparam int REC_CYC   = ns_to_cyc(T_WE_RECOV_NS, CLK_PERIOD_NS);
    localparam int RD_CYC    = max_of(ns_to_cyc(T_ADDR_ACC_NS, CLK_PERIOD_NS),
                                      ns_to_cyc(T_OE_ACC_NS, CLK_PERIOD_NS));
    localparam int TURN_CYC  = ns_to_cyc(T_BUS_OFF_NS, CLK_PERIOD_NS);
    localparam int TMR_MAX   = max_of(RD_CYC, max_of(PULSE_CYC, REC_CYC));
    localparam int TMR_W     = max_of(1, $clog2(TMR_MAX));
    localparam int TURN_W    = max_of(1, $clog2(TURN_CYC + 1));

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_last;
    logic             turn_ok_next;

    sramc_phase_tmr #(
        .W(TMR_W)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sramc_turn_guard #(
        .TURN_CYC(TURN_CYC),
        .W       (TURN_W)
    ) u_turn (
        .clk     (clk),
        .rst_n   (rst_n),
        .oe_n    (mem_oe_n),
        .ok_next (turn_ok_next)
    );

    sramc_seq #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .TMR_W    (TMR_W),
        .RD_CYC   (RD_CYC),
        .PULSE_CYC(PULSE_CYC),
        .REC_CYC  (REC_CYC)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_req     (host_req),
        .host_wr      (host_wr),
        .host_addr    (host_addr),
        .host_wdata   (host_wdata),
        .mem_rdata    (mem_dq_in),
        .tmr_last     (tmr_last),
        .turn_ok_next (turn_ok_next),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .rdata        (host_rdata),
        .done         (host_done),
        .ce           (mem_ce),
        .cs_n         (mem_cs_n),
        .we_n         (mem_we_n),
        .oe_n         (mem_oe_n),
        .drv          (mem_dq_oe),
        .addr         (mem_addr),
        .wdata        (mem_dq_out)
    );

endmodule

// File: rtl/sramc_chk.sv
module sramc_chk #(
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    parameter int PULSE_CYC = 2,
    parameter int REC_CYC   = 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce,
    input logic              cs_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [DATA_W-1:0] dq_out,
    input logic [ADDR_W-1:0] addr,
    input logic              done
);
    logic [7:0] lo_cnt, hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= 8'd0;
            hi_cnt <= 8'hFF;
        end else if (!we_n) begin
            lo_cnt <= (lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 8'd1;
            hi_cnt <= 8'd0;
        end else begin
            lo_cnt <= 8'd0;
            hi_cnt <= (hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 8'd1;
        end
    end

    // R4
    we_needs_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (!cs_n && ce && oe_n));

    // R4
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (int'(lo_cnt) >= PULSE_CYC));

    // R2
    read_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> (!cs_n && we_n && ce));

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);

    // R5
    write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!we_n && !$past(we_n)) |-> ($stable(addr) && $stable(dq_out) && dq_oe));

    // R5
    data_before_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> $past(dq_oe));

    // R6
    recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_n) |-> (int'(hi_cnt) >= REC_CYC));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && we_n && oe_n && ce));

endmodule

bind sram_timed_ctrl sramc_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PULSE_CYC(PULSE_CYC),
    .REC_CYC  (REC_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce     (mem_ce),
    .cs_n   (mem_cs_n),
    .we_n   (mem_we_n),
    .oe_n   (mem_oe_n),
    .dq_oe  (mem_dq_oe),
    .dq_out (mem_dq_out),
    .addr   (mem_addr),
    .done   (host_done)
);

// File: tb/sim_sram_timed_ctrl.sv
module sim_sram_timed_ctrl;
    localparam int CLK_NS = 10;
    // Expected counts from the requirements, computed here
    localparam int B_RD    = 3;   // max(ceil(25/10), ceil(9/10))
    localparam int B_PULSE = 2;   // max(ceil(20/10), ceil(15/10))
    localparam int B_REC   = 1;   // ceil(5/10) -> 1
    localparam int B_TURN  = 1;   // ceil(10/10)
    localparam int B_DSU   = 2;   // ceil(15/10)

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_wr = 1'b0;
    logic [14:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        host_done;
    logic        mem_ce, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [14:0] mem_addr;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    always #(CLK_NS / 2) clk = ~clk;

    sram_timed_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_done(host_done), .mem_ce(mem_ce), .mem_cs_n(mem_cs_n),
        .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- memory model and pin monitor ----------------
    logic [7:0] model [int];
    logic [7:0] mem_val = 8'h00;
    int  vcnt = 0;
    logic rd_en;
    logic prev_we = 1'b1, prev_drv = 1'b0;
    logic [14:0] prev_addr = '0;
    logic [7:0]  prev_dq = '0;
    logic [14:0] wa = '0;
    logic [7:0]  wd = '0;
    int lo_run = 0, hi_run = 100, drv_run = 0, oe_hi = 100;
    int pulse_len = 0, setup_len = 0, rec_len = 0, gap_len = 0, we_falls = 0;

    function automatic logic [7:0] peek(input int a);
        return model.exists(a) ? model[a] : 8'h00;
    endfunction

    assign rd_en     = !mem_cs_n && mem_ce && !mem_oe_n && mem_we_n;
    assign mem_dq_in = (rd_en && vcnt >= B_RD) ? mem_val : 8'hEE;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!mem_we_n) begin
                if (prev_we) begin
                    rec_len = hi_run;
                    we_falls++;
                end
                lo_run++;
                hi_run = 0;
                wa = mem_addr;
                wd = mem_dq_out;
            end else begin
                if (!prev_we) begin
                    pulse_len = lo_run;
                    setup_len = drv_run;
                    model[int'(wa)] = wd;
                end
                lo_run = 0;
                if (hi_run < 100) hi_run++;
            end
            if (mem_dq_oe && !prev_drv) gap_len = oe_hi;
            if (mem_dq_oe) drv_run = (prev_drv && mem_dq_out == prev_dq) ? drv_run + 1 : 1;
            else drv_run = 0;
            if (mem_oe_n) begin
                if (oe_hi < 100) oe_hi++;
            end else oe_hi = 0;
            if (rd_en) vcnt = (mem_addr == prev_addr) ? vcnt + 1 : 1;
            else vcnt = 0;
            mem_val = peek(int'(mem_addr));
            prev_we   = mem_we_n;
            prev_drv  = mem_dq_oe;
            prev_dq   = mem_dq_out;
            prev_addr = mem_addr;
        end
    end

    // ---------------- helpers ----------------
    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_done(output int lat);
        lat = 0;
        while (!host_done && lat < 60) begin
            @(negedge clk);
            lat++;
        end
        check(host_done, "R8 done timeout", lat, 0);
    endtask

    task automatic access(input logic wr, input logic [14:0] a, input logic [7:0] d,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        host_req = 1'b1; host_wr = wr; host_addr = a; host_wdata = d;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        wait_done(lat);
        rd = host_rdata;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(mem_ce == 1'b0, "R1 ce in reset", mem_ce, 0);
        check(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
              {mem_cs_n, mem_we_n, mem_oe_n}, 3'b111);
        check(!mem_dq_oe, "R1 driver in reset", mem_dq_oe, 0);
        check(!host_done, "R1 done in reset", host_done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check(mem_ce == 1'b1, "R1 ce idle", mem_ce, 1);
        check(mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 idle deselect",
              {mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe}, 4'b1110);
    endtask

    task automatic t_write_read();
        logic [7:0] rd;
        int lat;
        access(1'b1, 15'h0123, 8'hA5, rd, lat);
        check(lat == 1 + B_PULSE + B_REC, "R8 write latency", lat, 1 + B_PULSE + B_REC);
        check(pulse_len == B_PULSE, "R4 pulse width", pulse_len, B_PULSE);
        check(setup_len >= B_DSU, "R5 data setup", setup_len, B_DSU);
        check(peek(15'h0123) == 8'hA5, "R5 stored byte", peek(15'h0123), 8'hA5);
        @(negedge clk);
        check(!host_done, "R8 done one cycle", host_done, 0);
        access(1'b0, 15'h0123, 8'h00, rd, lat);
        check(rd == 8'hA5, "R2 read data", rd, 8'hA5);
        check(lat == B_RD + 1, "R3 read latency", lat, B_RD + 1);
    endtask

    task automatic t_corners();
        logic [7:0] rd;
        int lat;
        access(1'b1, 15'h7FFF, 8'h3C, rd, lat);
        access(1'b1, 15'h0000, 8'hC3, rd, lat);
        access(1'b0, 15'h7FFF, 8'h00, rd, lat);
        check(rd == 8'h3C, "R2 top address", rd, 8'h3C);
        access(1'b0, 15'h0000, 8'h00, rd, lat);
        check(rd == 8'hC3, "R2 zero address", rd, 8'hC3);
        check(mem_ce && mem_cs_n, "R1 deselect after read", {mem_ce, mem_cs_n}, 2'b11);
    endtask

    task automatic t_back_to_back();
        logic [7:0] rd;
        int lat;
        access(1'b1, 15'h0010, 8'h11, rd, lat);
        access(1'b1, 15'h0011, 8'h22, rd, lat);
        check(rec_len >= B_REC, "R6 recovery", rec_len, B_REC);
        check(peek(15'h0010) == 8'h11, "R5 first of pair", peek(15'h0010), 8'h11);
        check(peek(15'h0011) == 8'h22, "R5 second of pair", peek(15'h0011), 8'h22);
    endtask

    task automatic t_read_then_write();
        int lat;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 15'h0123;
        @(posedge clk);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 15'h0456; host_wdata = 8'h77;
        wait_done(lat);
        check(host_rdata == 8'hA5, "R2 read before write", host_rdata, 8'hA5);
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b0;
        wait_done(lat);
        check(gap_len >= B_TURN, "R7 turnaround", gap_len, B_TURN);
        check(peek(15'h0456) == 8'h77, "R7 write after read", peek(15'h0456), 8'h77);
    endtask

    task automatic t_ignore();
        logic [7:0] rd;
        int lat, falls0, extra;
        falls0 = we_falls;
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b0; host_addr = 15'h7FFF;
        @(posedge clk);
        @(negedge clk);
        host_req = 1'b1; host_wr = 1'b1; host_addr = 15'h0200; host_wdata = 8'h99;
        @(negedge clk);
        host_req = 1'b0;
        wait_done(lat);
        check(host_rdata == 8'h3C, "R9 busy read data", host_rdata, 8'h3C);
        extra = 0;
        repeat (6) begin
            @(negedge clk);
            if (host_done) extra++;
        end
        check(extra == 0, "R9 no extra done", extra, 0);
        check(we_falls == falls0, "R9 no write pulse", we_falls, falls0);
        access(1'b0, 15'h0200, 8'h00, rd, lat);
        check(rd == 8'h00, "R9 memory untouched", rd, 8'h00);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_write_read();
        t_corners();
        t_back_to_back();
        t_read_then_write();
        t_ignore();
        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule